// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the automatic part of interrupt handling for an 8-bit core. The core's arbiter picks a source. Once the current instruction has finished, it raises `accept_i` together with the source index. The sequencer then saves the return context on the stack: the high byte of the program counter, then the low byte, then the status register. It fetches the two-byte handler address from the vector table and sets the interrupt-disable flag in the status value it hands back. From the accepting cycle to the handler's first cycle takes a fixed seven cycles.

On a return-from-interrupt, the decoder raises `rti_i`. The sequencer pops the status register, then the low PC byte, then the high PC byte, and hands the restored values back after a fixed six cycles.

All memory traffic uses one byte-wide bus with an asynchronous read and a write strobe. The stack occupies page 0x01. A push writes to 0x0100+SP and then decrements SP. A pop increments SP and then reads. Source n has its vector low byte at 0xFFFC−2n and its high byte at 0xFFFD−2n.

Top module: `irq_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_we_o` are 0, and `pc_o`, `sp_o` and `ps_o` are 0.
- R2: When `accept_i` is sampled high while idle, `busy_o` is high for the next 7 cycles. `done_o` is high only in the 7th of these cycles, when `pc_o` holds the handler address.
- R3: Entry writes three bytes in this order: PC[15:8] to 0x0100+SP, PC[7:0] to 0x0100+((SP−1) mod 256), and the status byte to 0x0100+((SP−2) mod 256). At done, `sp_o` = (SP−3) mod 256.
- R4: For source index n, the handler address is read low byte from 0xFFFC−2n and high byte from 0xFFFD−2n, and appears as `pc_o` = {high, low}.
- R5: The status byte pushed on entry is `ps_i` unchanged. At entry done, `ps_o` equals `ps_i` with bit 2 (interrupt disable) set.
- R6: When `rti_i` is sampled high while idle, the block pops the status byte from 0x0100+((SP+1) mod 256), PC[7:0] from +2 and PC[15:8] from +3. `done_o` rises in the 6th busy cycle with `ps_o`, `pc_o` restored and `sp_o` = (SP+3) mod 256.
- R7: If `accept_i` and `rti_i` are both high while idle, the entry sequence runs and no return is performed.
- R8: `accept_i` and `rti_i` are ignored while `busy_o` is high. No further sequence starts, and the bus carries no additional traffic.
- R9: `done_o` is a single-cycle pulse. `mem_we_o` is high in exactly three cycles of each entry and in no cycle of a return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted at an instruction boundary |
| vec_idx_i | input | IDX_W | Index of the accepted source |
| rti_i | input | 1 | Return-from-interrupt request |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 8 | Current stack pointer |
| ps_i | input | 8 | Current processor status |
| mem_addr_o | output | 16 | Bus address |
| mem_wdata_o | output | 8 | Bus write data |
| mem_we_o | output | 1 | Bus write strobe |
| mem_rdata_i | input | 8 | Bus read data, valid in the same cycle as the address |
| pc_o | output | 16 | Updated program counter, valid at done |
| sp_o | output | 8 | Updated stack pointer, valid at done |
| ps_o | output | 8 | Updated status, valid at done |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of a sequence |

## Verification
A state counter that slips shows up as `done_o` arriving a cycle early or late, or as a write outside the three push slots. Either is visible within the seven-cycle window of the same sequence. A wrong stack-pointer step or a swapped push slot puts a byte at the wrong stack address or in the wrong order. Running a return straight after each entry exposes this on `pc_o` and `ps_o` within six cycles, because the pops read back what the pushes stored. A wrong vector offset shows on `pc_o` at the entry's done cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_PREP,
    ST_E_PCH,
    ST_E_PCL,
    ST_E_PS,
    ST_E_VLO,
    ST_E_VHI,
    ST_E_DONE,
    ST_R_PREP,
    ST_R_PS,
    ST_R_PCL,
    ST_R_PCH,
    ST_R_SETTLE,
    ST_R_DONE
  } seq_state_e;

  localparam logic [7:0] STACK_PAGE = 8'h01;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       rti_i,
  output seq_state_e state_o,
  output logic       start_entry_o,
  output logic       start_ret_o
);
  seq_state_e state_q, state_d;

  // entry has priority over return when both arrive together
  assign start_entry_o = (state_q == ST_IDLE) && accept_i;
  assign start_ret_o   = (state_q == ST_IDLE) && !accept_i && rti_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_entry_o)    state_d = ST_E_PREP;
        else if (start_ret_o) state_d = ST_R_PREP;
      end
      ST_E_PREP:   state_d = ST_E_PCH;
      ST_E_PCH:    state_d = ST_E_PCL;
      ST_E_PCL:    state_d = ST_E_PS;
      ST_E_PS:     state_d = ST_E_VLO;
      ST_E_VLO:    state_d = ST_E_VHI;
      ST_E_VHI:    state_d = ST_E_DONE;
      ST_E_DONE:   state_d = ST_IDLE;
      ST_R_PREP:   state_d = ST_R_PS;
      ST_R_PS:     state_d = ST_R_PCL;
      ST_R_PCL:    state_d = ST_R_PCH;
      ST_R_PCH:    state_d = ST_R_SETTLE;
      ST_R_SETTLE: state_d = ST_R_DONE;
      ST_R_DONE:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned I_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_state_e       state_i,
  input  logic             start_entry_i,
  input  logic             start_ret_i,
  input  logic [15:0]      pc_i,
  input  logic [7:0]       sp_i,
  input  logic [7:0]       ps_i,
  input  logic [IDX_W-1:0] vec_idx_i,
  input  logic [7:0]       rdata_i,
  output logic [15:0]      pc_o,
  output logic [7:0]       sp_o,
  output logic [7:0]       ps_o,
  output logic [IDX_W-1:0] vec_idx_o
);
  localparam logic [7:0] I_MASK = 8'(1) << I_BIT;

  logic [15:0]      pc_q;
  logic [7:0]       sp_q, ps_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sp_q  <= '0;
      ps_q  <= '0;
      idx_q <= '0;
    end else if (start_entry_i) begin
      pc_q  <= pc_i;
      sp_q  <= sp_i;
      ps_q  <= ps_i;
      idx_q <= vec_idx_i;
    end else if (start_ret_i) begin
      sp_q <= sp_i;
    end else begin
      unique case (state_i)
        ST_E_PCH, ST_E_PCL: sp_q <= sp_q - 8'd1;
        ST_E_PS: begin
          sp_q <= sp_q - 8'd1;
          ps_q <= ps_q | I_MASK; // set after the original was pushed
        end
        ST_E_VLO: pc_q[7:0]  <= rdata_i;
        ST_E_VHI: pc_q[15:8] <= rdata_i;
        ST_R_PS: begin
          sp_q <= sp_q + 8'd1;
          ps_q <= rdata_i;
        end
        ST_R_PCL: begin
          sp_q      <= sp_q + 8'd1;
          pc_q[7:0] <= rdata_i;
        end
        ST_R_PCH: begin
          sp_q       <= sp_q + 8'd1;
          pc_q[15:8] <= rdata_i;
        end
        default: ;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign ps_o      = ps_q;
  assign vec_idx_o = idx_q;
endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
  import irq_seq_pkg::*;
#(
  parameter int unsigned IDX_W   = 3,
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  seq_state_e       state_i,
  input  logic [15:0]      pc_i,
  input  logic [7:0]       sp_i,
  input  logic [7:0]       ps_i,
  input  logic [IDX_W-1:0] vec_idx_i,
  output logic [15:0]      addr_o,
  output logic [7:0]       wdata_o,
  output logic             we_o
);
  logic [15:0] vec_lo;
  logic [7:0]  sp_inc;

  assign vec_lo = VEC_TOP - (16'(vec_idx_i) << 1);
  assign sp_inc = sp_i + 8'd1;

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    unique case (state_i)
      ST_E_PCH: begin
        addr_o = {STACK_PAGE, sp_i}; wdata_o = pc_i[15:8]; we_o = 1'b1;
      end
      ST_E_PCL: begin
        addr_o = {STACK_PAGE, sp_i}; wdata_o = pc_i[7:0]; we_o = 1'b1;
      end
      ST_E_PS: begin
        addr_o = {STACK_PAGE, sp_i}; wdata_o = ps_i; we_o = 1'b1;
      end
      ST_E_VLO: addr_o = vec_lo;
      ST_E_VHI: addr_o = vec_lo + 16'd1;
      ST_R_PS, ST_R_PCL, ST_R_PCH: addr_o = {STACK_PAGE, sp_inc};
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned I_BIT   = 2,
  parameter logic [15:0] VEC_TOP = 16'hFFFC,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [IDX_W-1:0] vec_idx_i,
  input  logic             rti_i,
  input  logic [15:0]      pc_i,
  input  logic [7:0]       sp_i,
  input  logic [7:0]       ps_i,
  output logic [15:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             mem_we_o,
  input  logic [7:0]       mem_rdata_i,
  output logic [15:0]      pc_o,
  output logic [7:0]       sp_o,
  output logic [7:0]       ps_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state;
  logic             start_entry, start_ret;
  logic [15:0]      pc_q;
  logic [7:0]       sp_q, ps_q;
  logic [IDX_W-1:0] idx_q;

  irq_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept_i),
    .rti_i         (rti_i),
    .state_o       (state),
    .start_entry_o (start_entry),
    .start_ret_o   (start_ret)
  );

  irq_seq_ctx #(.IDX_W(IDX_W), .I_BIT(I_BIT)) u_ctx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .start_entry_i (start_entry),
    .start_ret_i   (start_ret),
    .pc_i          (pc_i),
    .sp_i          (sp_i),
    .ps_i          (ps_i),
    .vec_idx_i     (vec_idx_i),
    .rdata_i       (mem_rdata_i),
    .pc_o          (pc_q),
    .sp_o          (sp_q),
    .ps_o          (ps_q),
    .vec_idx_o     (idx_q)
  );

  irq_seq_bus #(.IDX_W(IDX_W), .VEC_TOP(VEC_TOP)) u_bus (
    .state_i   (state),
    .pc_i      (pc_q),
    .sp_i      (sp_q),
    .ps_i      (ps_q),
    .vec_idx_i (idx_q),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .we_o      (mem_we_o)
  );

  assign pc_o   = pc_q;
  assign sp_o   = sp_q;
  assign ps_o   = ps_q;
  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_E_DONE) || (state == ST_R_DONE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int unsigned I_BIT = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        accept_i,
  input logic        rti_i,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic [7:0]  ps_o,
  input logic        busy_o,
  input logic        done_o
);
  logic [3:0] cyc_q;
  logic [1:0] wr_q;
  logic       entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q   <= '0;
      wr_q    <= '0;
      entry_q <= 1'b0;
    end else if (!busy_o && (accept_i || rti_i)) begin
      cyc_q   <= 4'd1;
      wr_q    <= '0;
      entry_q <= accept_i;
    end else if (busy_o) begin
      if (cyc_q != 4'hF) cyc_q <= cyc_q + 4'd1;
      if (mem_we_o && wr_q != 2'd3) wr_q <= wr_q + 2'd1;
    end
  end

  AST_START_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && accept_i) |=> busy_o) else $error("start"); // R2
  AST_ENTRY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && entry_q) |-> (cyc_q == 4'd7)) else $error("entry len"); // R2
  AST_RET_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !entry_q) |-> (cyc_q == 4'd6)) else $error("ret len"); // R6
  AST_WR_STACK_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[15:8] == 8'h01)) else $error("page"); // R3
  AST_I_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && entry_q) |-> ps_o[I_BIT]) else $error("i flag"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("pulse"); // R9
  AST_WR_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_q == (entry_q ? 2'd3 : 2'd0))) else $error("wr count"); // R9
  AST_WE_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o) else $error("we idle"); // R8
endmodule

bind irq_seq irq_seq_chk #(.I_BIT(I_BIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accept_i   (accept_i),
  .rti_i      (rti_i),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .ps_o       (ps_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/irq_seq_tb_top.sv
`timescale 1ns/1ps
module irq_seq_tb_top;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned IDX_W   = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             accept_i = 1'b0, rti_i = 1'b0;
  logic [IDX_W-1:0] vec_idx_i = '0;
  logic [15:0]      pc_i = '0;
  logic [7:0]       sp_i = '0, ps_i = '0;
  logic [15:0]      mem_addr;
  logic [7:0]       mem_wdata, mem_rdata;
  logic             mem_we;
  logic [15:0]      pc_o;
  logic [7:0]       sp_o, ps_o;
  logic             busy_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  stack_m [256];

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [15:0] vec_pc(input int idx);
    logic [15:0] lo_a;
    lo_a = 16'hFFFC - 16'(2 * idx);
    return {rom_byte(lo_a + 16'd1), rom_byte(lo_a)};
  endfunction

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stack_m[mem_addr[7:0]] : rom_byte(mem_addr);

  always @(posedge clk) if (rst_n && mem_we) stack_m[mem_addr[7:0]] <= mem_wdata;

  irq_seq #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept_i), .vec_idx_i(vec_idx_i),
    .rti_i(rti_i), .pc_i(pc_i), .sp_i(sp_i), .ps_i(ps_i),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .pc_o(pc_o), .sp_o(sp_o), .ps_o(ps_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: every write is compared against the scoreboard (R3, R9)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3", "push addr/data",
            {8'h0, mem_addr, mem_wdata}, {8'h0, e});
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] ps,
                          input int idx, input bit with_rti, input bit poke);
    logic [15:0] exp_pc;
    exp_pc = vec_pc(idx);
    exp_q.push_back({8'h01, sp, pc[15:8]});
    exp_q.push_back({8'h01, sp - 8'd1, pc[7:0]});
    exp_q.push_back({8'h01, sp - 8'd2, ps});
    @(negedge clk);
    accept_i = 1'b1; rti_i = with_rti; pc_i = pc; sp_i = sp; ps_i = ps;
    vec_idx_i = IDX_W'(idx);
    @(negedge clk);
    accept_i = 1'b0; rti_i = 1'b0; pc_i = 16'hDEAD; sp_i = 8'h55; ps_i = 8'hAA;
    for (int k = 1; k <= 7; k++) begin
      if (k > 1) @(negedge clk);
      chk(busy_o == 1'b1, "R2", "busy during entry", 32'(busy_o), 32'd1);
      chk(done_o == (k == 7), "R2", "done timing entry", 32'(done_o), 32'(k == 7));
      if (poke) begin
        accept_i = (k == 3); rti_i = (k == 3); // R8
      end
    end
    chk(pc_o == exp_pc, "R4", "handler pc", 32'(pc_o), 32'(exp_pc));
    chk(sp_o == sp - 8'd3, "R3", "sp after pushes", 32'(sp_o), 32'(sp - 8'd3));
    chk(ps_o == (ps | 8'h04), "R5", "ps with disable set", 32'(ps_o), 32'(ps | 8'h04));
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", "idle after entry",
        {30'h0, busy_o, done_o}, 32'h0);
    chk(exp_q.size() == 0, "R9", "all pushes seen", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic do_return(input logic [7:0] sp, input logic [15:0] exp_pc,
                           input logic [7:0] exp_ps);
    @(negedge clk);
    rti_i = 1'b1; sp_i = sp;
    @(negedge clk);
    rti_i = 1'b0; sp_i = 8'h33;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      chk(busy_o == 1'b1, "R6", "busy during return", 32'(busy_o), 32'd1);
      chk(done_o == (k == 6), "R6", "done timing return", 32'(done_o), 32'(k == 6));
    end
    chk(pc_o == exp_pc, "R6", "restored pc", 32'(pc_o), 32'(exp_pc));
    chk(ps_o == exp_ps, "R6", "restored ps", 32'(ps_o), 32'(exp_ps));
    chk(sp_o == sp + 8'd3, "R6", "sp after pops", 32'(sp_o), 32'(sp + 8'd3));
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done is one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) stack_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0 && mem_we == 0, "R1", "reset flags",
        {29'h0, busy_o, done_o, mem_we}, 32'h0);
    chk(pc_o == 0 && sp_o == 0 && ps_o == 0, "R1", "reset context",
        {pc_o, sp_o, ps_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R1", "idle after reset", 32'(busy_o), 32'd0);

    do_entry(16'h1234, 8'hF0, 8'h81, 0, 1'b0, 1'b0);
    do_return(8'hED, 16'h1234, 8'h81);

    // R3 stack pointer wrap across the page
    do_entry(16'hABCD, 8'h01, 8'h04, 5, 1'b0, 1'b0);
    do_return(8'hFE, 16'hABCD, 8'h04);

    // R7 both requests together; R8 requests while busy
    do_entry(16'h0F0E, 8'h80, 8'h30, 7, 1'b1, 1'b1);
    accept_i = 1'b0; rti_i = 1'b0;
    chk(sp_o == 8'h7D, "R7", "entry won over return", 32'(sp_o), 32'h7D);
    do_return(8'h7D, 16'h0F0E, 8'h30);

    do_entry(16'h8001, 8'h10, 8'h00, 3, 1'b0, 1'b0);
    do_return(8'h0D, 16'h8001, 8'h00);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule